// File: doc/BRIEF.md
# Level-2 Cache Controller Register Stub

This block gives software the register interface of a level-2 cache controller. It has no cache behind it. Software can program the control, auxiliary control, tag latency, data latency and address filter registers. It can read a fixed identification word and a cache type word. Every cache maintenance poll reads as finished, so boot and maintenance code that waits on those registers runs through at once.

The bus is a single-beat request port: a request strobe, a write enable, an address and write data. The block decodes only the low 12 bits of the address, which gives a 4 KB window. Each request gets exactly one response, one cycle later. The response carries read data and an error flag, which is raised when the offset is unmapped. Reading the cache type word has a side effect: fields taken from auxiliary control are ORed into a stored cache type value. Because the stored value is updated on every such read, bits accumulate across reads until the next reset.

Top module: `cc_stub_regs`

## Requirements
- R1: After reset, the registers read as follows: control 0, auxiliary control 0x02020000, tag control 0, data control 0, filter start 0, filter end 0. Outputs `rsp_valid` and `rsp_err` are low while no request is pending.
- R2: Offset 0x000 reads 0x410000C8. A write to offset 0x000 changes nothing and is flagged as an error.
- R3: Offsets 0x730 through 0x7FC read as 0 with no error. Writes there are dropped with no error. Offsets 0x72C and 0x800 are unmapped.
- R4: Control at 0x100 keeps only bit 0 of a write. Bits 31:1 always read as 0.
- R5: Auxiliary control (0x104), tag control (0x108), data control (0x10C), filter start (0xC00) and filter end (0xC04) store and return all 32 bits.
- R6: A read of 0x004 forms a field f. In f, bits 4:2 are auxiliary control bits 19:17, bit 1 is 0, and bit 0 is auxiliary control bit 16. The stored cache type (default 0x1C100100) is ORed with (f<<18)|(f<<6). The result is stored back and returned. Bits that were set stay set after auxiliary control changes.
- R7: Offsets 0xF40, 0xF60 and 0xF80 read as 0. Writes there are dropped. Neither raises an error.
- R8: Any other offset reads as 0 and drops writes. A write to 0x004 is also treated this way. Such an access raises `rsp_err` for exactly the one response cycle of that access.
- R9: Each request cycle is followed, in the next cycle, by exactly one `rsp_valid` pulse. On a write, `rsp_rdata` is 0.
- R10: Reset returns the stored cache type to its default, so accumulation starts again.
- R11: Address bits above bit 11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one access per cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (32) | Byte address; only bits 11:0 are decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after each request |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| rsp_err | output | 1 | Unmapped-offset flag, valid with rsp_valid |

## Verification
Two things can meet in one cycle. A cache type read both updates the stored word and returns it. A write to auxiliary control can be followed directly by such a read, so the newly written fields must show up in the word that read returns. The bench issues an auxiliary control write and a cache type read back to back, with no idle cycle between them. It predicts the accumulated word from its own model and then clears auxiliary control. A second read confirms the bits persisted. Back-to-back unmapped and mapped accesses also check that the error pulse lasts only one cycle.

// File: rtl/cc_stub_pkg.sv
package cc_stub_pkg;

    localparam int DATA_W   = 32;
    localparam int OFF_W    = 12;

    localparam logic [DATA_W-1:0] ID_WORD       = 32'h4100_00C8;
    localparam logic [DATA_W-1:0] AUX_RST       = 32'h0202_0000;
    localparam logic [DATA_W-1:0] CTYPE_DEFAULT = 32'h1C10_0100;

    localparam logic [OFF_W-1:0] MAINT_LO = 12'h730;
    localparam logic [OFF_W-1:0] MAINT_HI = 12'h800;

    typedef enum logic [3:0] {
        RG_ID, RG_CTYPE, RG_CTRL, RG_AUX, RG_TAG, RG_DAT,
        RG_FSTART, RG_FEND, RG_MAINT, RG_SILENT, RG_BAD
    } region_e;

    typedef struct packed {
        logic              ctrl_en;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] tag_lat;
        logic [DATA_W-1:0] dat_lat;
        logic [DATA_W-1:0] flt_lo;
        logic [DATA_W-1:0] flt_hi;
    } cfg_t;

    function automatic region_e decode_off(input logic [OFF_W-1:0] off);
        region_e r;
        if (off >= MAINT_LO && off < MAINT_HI) begin
            r = RG_MAINT;
        end else begin
            case (off)
                12'h000: r = RG_ID;
                12'h004: r = RG_CTYPE;
                12'h100: r = RG_CTRL;
                12'h104: r = RG_AUX;
                12'h108: r = RG_TAG;
                12'h10C: r = RG_DAT;
                12'hC00: r = RG_FSTART;
                12'hC04: r = RG_FEND;
                12'hF40, 12'hF60, 12'hF80: r = RG_SILENT;
                default: r = RG_BAD;
            endcase
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctype_mask(input logic [DATA_W-1:0] aux);
        logic [4:0] f;
        f = {aux[19:17], 1'b0, aux[16]};
        return (DATA_W'(f) << 18) | (DATA_W'(f) << 6);
    endfunction

endpackage

// File: rtl/cc_stub_decode.sv
module cc_stub_decode
    import cc_stub_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    logic unused_hi;
    assign unused_hi = ^addr;
    assign region    = decode_off(addr[OFF_W-1:0]);
endmodule

// File: rtl/cc_stub_regfile.sv
module cc_stub_regfile
    import cc_stub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              ct_rd,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] ct_upd
);
    cfg_t              cfg_q;
    logic [DATA_W-1:0] ct_q;

    assign ct_upd = ct_q | ctype_mask(cfg_q.aux);
    assign cfg    = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.ctrl_en <= 1'b0;
            cfg_q.aux     <= AUX_RST;
            cfg_q.tag_lat <= '0;
            cfg_q.dat_lat <= '0;
            cfg_q.flt_lo  <= '0;
            cfg_q.flt_hi  <= '0;
            ct_q          <= CTYPE_DEFAULT;
        end else begin
            if (wr_en) begin
                case (region)
                    RG_CTRL:   cfg_q.ctrl_en <= wdata[0];
                    RG_AUX:    cfg_q.aux     <= wdata;
                    RG_TAG:    cfg_q.tag_lat <= wdata;
                    RG_DAT:    cfg_q.dat_lat <= wdata;
                    RG_FSTART: cfg_q.flt_lo  <= wdata;
                    RG_FEND:   cfg_q.flt_hi  <= wdata;
                    default: ;
                endcase
            end
            if (ct_rd) ct_q <= ct_upd;
        end
    end

    // R6: the stored cache type word never loses a set bit
    assert_ct_keeps_bits_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ct_q & $past(ct_q)) == $past(ct_q)));

endmodule

// File: rtl/cc_stub_resp.sv
module cc_stub_resp
    import cc_stub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  region_e           region,
    input  cfg_t              cfg,
    input  logic [DATA_W-1:0] ct_upd,
    output logic              valid,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    logic [DATA_W-1:0] rd_mux;
    logic              bad_acc;

    always_comb begin
        rd_mux = '0;
        if (!we) begin
            case (region)
                RG_ID:     rd_mux = ID_WORD;
                RG_CTYPE:  rd_mux = ct_upd;
                RG_CTRL:   rd_mux = {{(DATA_W-1){1'b0}}, cfg.ctrl_en};
                RG_AUX:    rd_mux = cfg.aux;
                RG_TAG:    rd_mux = cfg.tag_lat;
                RG_DAT:    rd_mux = cfg.dat_lat;
                RG_FSTART: rd_mux = cfg.flt_lo;
                RG_FEND:   rd_mux = cfg.flt_hi;
                default:   rd_mux = '0;
            endcase
        end
    end

    assign bad_acc = (region == RG_BAD) ||
                     (we && (region == RG_ID || region == RG_CTYPE));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            err   <= 1'b0;
            rdata <= '0;
        end else begin
            valid <= req;
            err   <= req && bad_acc;
            rdata <= req ? rd_mux : '0;
        end
    end

    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req |=> valid);
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        !req |=> !valid);
    assert_err_within_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> valid);

endmodule

// File: rtl/cc_stub_regs.sv
module cc_stub_regs
    import cc_stub_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    region_e           region;
    cfg_t              cfg;
    logic [DATA_W-1:0] ct_upd;

    cc_stub_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (req_addr),
        .region (region)
    );

    cc_stub_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req && req_we),
        .ct_rd  (req && !req_we && region == RG_CTYPE),
        .region (region),
        .wdata  (req_wdata),
        .cfg    (cfg),
        .ct_upd (ct_upd)
    );

    cc_stub_resp u_rsp (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .we     (req_we),
        .region (region),
        .cfg    (cfg),
        .ct_upd (ct_upd),
        .valid  (rsp_valid),
        .rdata  (rsp_rdata),
        .err    (rsp_err)
    );

    assert_ctrl_high_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !req_we && region == RG_CTRL) |=> (rsp_rdata[31:1] == '0));
    assert_maint_done_R3: assert property (@(posedge clk) disable iff (rst)
        (req && region == RG_MAINT) |=> (!rsp_err && rsp_rdata == '0));
    assert_id_word_R2: assert property (@(posedge clk) disable iff (rst)
        (req && !req_we && region == RG_ID) |=> (rsp_rdata == ID_WORD && !rsp_err));

endmodule

// File: tb/sim_cc_stub_regs.sv
module sim_cc_stub_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    always #5 clk = ~clk;

    cc_stub_regs #(.ADDR_W(32)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    typedef struct {
        int unsigned cyc;
        logic [31:0] d;
        logic        e;
        string       r;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    int unsigned cyc = 0;
    logic [31:0] m_aux;
    logic [31:0] m_ct;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mask_of(input logic [31:0] a);
        logic [4:0] f;
        f = {a[19], a[18], a[17], 1'b0, a[16]};
        return ({27'd0, f} << 18) | ({27'd0, f} << 6);
    endfunction

    task automatic check(input bit ok, input string r, input logic [31:0] act,
                         input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp_v);
        end
    endtask

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       input logic [31:0] ed, input logic ee, input string r);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        q.push_back('{cyc, ed, ee, r});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0; req_we = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_aux = 32'h0202_0000;
        m_ct  = 32'h1C10_0100;
    endtask

    task automatic rd_ct(input string r);
        m_ct = m_ct | mask_of(m_aux);
        acc(1'b0, 32'h004, 32'h0, m_ct, 1'b0, r);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].cyc + 1 == cyc) begin
                check(rsp_valid === 1'b1, {q[0].r, " valid"}, 32'(rsp_valid), 32'd1);
                check(rsp_rdata === q[0].d, {q[0].r, " rdata"}, rsp_rdata, q[0].d);
                check(rsp_err === q[0].e, {q[0].r, " err"}, 32'(rsp_err), 32'(q[0].e));
                void'(q.pop_front());
            end else if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
                check(1'b0, "R9 no request pending", {30'd0, rsp_valid, rsp_err}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R1 idle after reset",
              {30'd0, rsp_valid, rsp_err}, 32'd0);
        // R1 reset values
        acc(1'b0, 32'h100, 0, 32'h0, 1'b0, "R1 ctrl");
        acc(1'b0, 32'h104, 0, 32'h0202_0000, 1'b0, "R1 aux");
        acc(1'b0, 32'h108, 0, 32'h0, 1'b0, "R1 tag");
        acc(1'b0, 32'h10C, 0, 32'h0, 1'b0, "R1 data");
        acc(1'b0, 32'hC00, 0, 32'h0, 1'b0, "R1 fstart");
        acc(1'b0, 32'hC04, 0, 32'h0, 1'b0, "R1 fend");
        rd_ct("R6 first ctype");
        // R6 accumulation, back-to-back with aux write
        acc(1'b1, 32'h104, 32'h000F_0000, 32'h0, 1'b0, "R5 aux write");
        m_aux = 32'h000F_0000;
        rd_ct("R6 ctype after aux");
        check(m_ct == 32'h1C74_0740, "R6 model", m_ct, 32'h1C74_0740);
        acc(1'b1, 32'h104, 32'h0, 32'h0, 1'b0, "R5 aux clear");
        m_aux = 32'h0;
        rd_ct("R6 ctype sticky");
        // R2 identity
        acc(1'b0, 32'h000, 0, 32'h4100_00C8, 1'b0, "R2 id read");
        acc(1'b1, 32'h000, 32'hFFFF_FFFF, 32'h0, 1'b1, "R2 id write err");
        acc(1'b0, 32'h000, 0, 32'h4100_00C8, 1'b0, "R2 id unchanged");
        // R4 control
        acc(1'b1, 32'h100, 32'hFFFF_FFFF, 32'h0, 1'b0, "R4 ctrl write");
        acc(1'b0, 32'h100, 0, 32'h1, 1'b0, "R4 ctrl bit0");
        acc(1'b1, 32'h100, 32'hFFFF_FFFE, 32'h0, 1'b0, "R4 ctrl write2");
        acc(1'b0, 32'h100, 0, 32'h0, 1'b0, "R4 ctrl cleared");
        // R5 full registers
        acc(1'b1, 32'h104, 32'hA5A5_5A5A, 0, 1'b0, "R5 w aux");
        acc(1'b1, 32'h108, 32'h1234_5678, 0, 1'b0, "R5 w tag");
        acc(1'b1, 32'h10C, 32'hFFFF_0001, 0, 1'b0, "R5 w data");
        acc(1'b1, 32'hC00, 32'h8000_0000, 0, 1'b0, "R5 w fstart");
        acc(1'b1, 32'hC04, 32'hDEAD_BEEF, 0, 1'b0, "R5 w fend");
        m_aux = 32'hA5A5_5A5A;
        acc(1'b0, 32'h104, 0, 32'hA5A5_5A5A, 1'b0, "R5 r aux");
        acc(1'b0, 32'h108, 0, 32'h1234_5678, 1'b0, "R5 r tag");
        acc(1'b0, 32'h10C, 0, 32'hFFFF_0001, 1'b0, "R5 r data");
        acc(1'b0, 32'hC00, 0, 32'h8000_0000, 1'b0, "R5 r fstart");
        acc(1'b0, 32'hC04, 0, 32'hDEAD_BEEF, 1'b0, "R5 r fend");
        // R3 maintenance window and its edges
        acc(1'b0, 32'h730, 0, 32'h0, 1'b0, "R3 maint low");
        acc(1'b0, 32'h7FC, 0, 32'h0, 1'b0, "R3 maint high");
        acc(1'b1, 32'h750, 32'hFFFF_FFFF, 32'h0, 1'b0, "R3 maint write");
        acc(1'b0, 32'h72C, 0, 32'h0, 1'b1, "R3 below window");
        acc(1'b0, 32'h800, 0, 32'h0, 1'b1, "R3 above window");
        acc(1'b0, 32'h104, 0, 32'hA5A5_5A5A, 1'b0, "R3 aux untouched");
        // R7 silent offsets
        acc(1'b0, 32'hF40, 0, 32'h0, 1'b0, "R7 F40 read");
        acc(1'b1, 32'hF60, 32'h1, 32'h0, 1'b0, "R7 F60 write");
        acc(1'b0, 32'hF80, 0, 32'h0, 1'b0, "R7 F80 read");
        // R8 unmapped, one-cycle error
        acc(1'b0, 32'h200, 0, 32'h0, 1'b1, "R8 bad read");
        acc(1'b0, 32'h108, 0, 32'h1234_5678, 1'b0, "R8 err cleared");
        acc(1'b1, 32'h110, 32'h5555_5555, 32'h0, 1'b1, "R8 bad write");
        acc(1'b1, 32'h004, 32'hFFFF_FFFF, 32'h0, 1'b1, "R8 ctype write");
        rd_ct("R8 ctype not written");
        acc(1'b0, 32'h10C, 0, 32'hFFFF_0001, 1'b0, "R8 data untouched");
        idle(2);
        // R11 upper address bits ignored
        acc(1'b0, 32'hFFFF_F104, 0, 32'hA5A5_5A5A, 1'b0, "R11 aliased aux");
        acc(1'b1, 32'h1234_5108, 32'h0BAD_F00D, 32'h0, 1'b0, "R11 aliased write");
        acc(1'b0, 32'h108, 0, 32'h0BAD_F00D, 1'b0, "R11 readback");
        idle(3);
        // R10 reset restarts accumulation
        do_reset();
        rd_ct("R10 ctype default");
        check(m_ct == 32'h1C10_0100, "R10 model", m_ct, 32'h1C10_0100);
        acc(1'b0, 32'h108, 0, 32'h0, 1'b0, "R1 tag after reset");
        idle(4);
        check(q.size() == 0, "R9 all responses seen", q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule